// File: doc/BRIEF.md
# Eight-Channel Serial ADC Frame Controller

This block is the master side of the link to a 12-bit, eight-input successive-approximation converter. The converter is read over four wires: an active-low select, a serial clock, a command line towards the converter and a result line back from it. The block divides the system clock down to a serial clock with a 50% duty cycle. While a run request is held, it issues back-to-back 16-clock frames. Each frame carries a 3-bit input address to the converter and collects the 12-bit conversion result in return.

The converter answers one frame late: the value that comes back in a frame was converted on the input addressed in the frame before. The controller therefore holds the address it sent in a one-deep pipeline and tags each result with that held address. Results with no trustworthy tag are dropped. This covers the first frame after the select line falls, and, when a fixed input is chosen, any frame whose address differs from the one sent just before it.

Two modes are offered. In fixed mode the address comes from an input port. In scan mode an internal pointer visits the inputs in ascending order and wraps. The pointer survives stops and restarts and is cleared only by reset. The serial divider must be set so that the serial clock lands between 0.8 MHz and 3.2 MHz; the default of 40 system clocks per half period gives 2.5 MHz from a 200 MHz clock.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While and right after synchronous reset, the select output is high, the serial clock is high and result-valid is low. The scan pointer restarts at input 0, so the first scan frame after reset addresses input 0.
- R2: The serial clock stays high whenever the select output is high. Inside a frame, each high and each low phase lasts exactly HALF_DIV system clocks.
- R3: A frame holds the select output low for exactly 16 serial rising edges. The select output falls HALF_DIV cycles before the first falling edge. While run stays high, frames follow with no gap and select stays low. When run is low at the 16th rising edge, select rises HALF_DIV cycles after that edge.
- R4: The command line changes only on a serial falling edge or when select rises. It carries the address most significant bit first, on the 3rd, 4th and 5th rising edges of the frame (counting from 1), and is 0 on every other rising edge. In fixed mode the address is the chan_sel value present when the frame's first falling edge is issued.
- R5: The result line is sampled on each serial rising edge. The result is the last 12 samples of the frame, first sample most significant. The first 4 samples have no effect on the result.
- R6: Each delivered result carries, on res_chan, the address sent in the frame before the one that returned it.
- R7: No result is delivered for the first frame after select falls. In fixed mode, no result is delivered for a frame whose address differs from the previous frame's address.
- R8: In scan mode, successive frames address 0, 1, ..., N_CH-1 and then 0 again. The pointer does not move in fixed mode and is kept across a stop and restart.
- R9: res_valid is a single-cycle pulse, one per delivered result. Every frame not excluded by R7 delivers exactly one result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Keep issuing frames while high; sampled at each frame end |
| scan_mode | input | 1 | 1: scan inputs in order, 0: use chan_sel; taken at frame start |
| chan_sel | input | 3 | Input address used in fixed mode |
| adc_dout | input | 1 | Serial result line from the converter |
| adc_cs_n | output | 1 | Active-low converter select |
| adc_sclk | output | 1 | Serial clock to the converter, idles high |
| adc_din | output | 1 | Serial command line to the converter |
| res_valid | output | 1 | One-cycle pulse marking a delivered result |
| res_data | output | 12 | Conversion result |
| res_chan | output | 3 | Input address the result belongs to |

## Verification
The bench builds the block with HALF_DIV = 3, so one frame takes only 96 system clocks. Some forty frames then fit in a short run, covering scan wraparound past input 7, pointer continuity across sessions, and many fixed-mode channel changes that trigger the discard rule. N_CH keeps its default of 8, so the full 3-bit address space and its wrap are used. With the small divider, every half-period, the select lead and the select tail can be measured cycle-exactly on every edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int FRAME_BITS = 16;
  localparam int RES_W      = 12;
  localparam int ADDR_W     = 3;
  localparam int ADDR_FIRST = 2;
  localparam int BIT_IDX_W  = $clog2(FRAME_BITS);

  typedef logic [ADDR_W-1:0]     addr_t;
  typedef logic [RES_W-1:0]      res_t;
  typedef logic [FRAME_BITS-1:0] word_t;

  // Command-line value for a given bit slot of the frame.
  function automatic logic cmd_bit(input addr_t a, input logic [BIT_IDX_W-1:0] k);
    logic b;
    b = 1'b0;
    for (int i = 0; i < ADDR_W; i++) begin
      if (k == BIT_IDX_W'(ADDR_FIRST + i)) b = a[ADDR_W-1-i];
    end
    return b;
  endfunction

  // Scan pointer step with wrap at n inputs.
  function automatic addr_t step_addr(input addr_t a, input int n);
    if (int'(a) >= n - 1) return '0;
    return a + addr_t'(1);
  endfunction

  // Result field of a completed frame word: the trailing RES_W samples.
  function automatic res_t word_result(input word_t w);
    return w[RES_W-1:0];
  endfunction

endpackage

// File: rtl/adc_sclk_tick.sv
module adc_sclk_tick #(
  parameter int HALF_DIV = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic tick
);
  localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || hold)  cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adc_seq_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  tick,
  input  logic  run,
  input  logic  scan_mode,
  input  addr_t chan_sel,
  input  logic  dout,
  output logic  cs_n,
  output logic  sclk,
  output logic  din,
  output logic  busy,
  output logic  start_evt,
  output logic  done_evt,
  output addr_t frame_addr,
  output logic  frame_scan,
  output word_t frame_word
);
  localparam int PH_W = $clog2(2 * FRAME_BITS + 1);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(2 * FRAME_BITS - 1);
  localparam logic [PH_W-1:0] TAIL_PH = PH_W'(2 * FRAME_BITS);

  logic [PH_W-1:0]      ph;
  addr_t                ptr;
  addr_t                next_addr;
  logic [BIT_IDX_W-1:0] bit_idx;
  logic                 fall_evt, rise_evt, tail_evt;

  assign bit_idx   = ph[BIT_IDX_W:1];
  assign fall_evt  = tick && busy && (ph != TAIL_PH) && !ph[0];
  assign rise_evt  = tick && busy && ph[0];
  assign tail_evt  = tick && busy && (ph == TAIL_PH);
  assign next_addr = scan_mode ? ptr : chan_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n       <= 1'b1;
      sclk       <= 1'b1;
      din        <= 1'b0;
      busy       <= 1'b0;
      ph         <= '0;
      ptr        <= '0;
      frame_addr <= '0;
      frame_scan <= 1'b0;
      frame_word <= '0;
      start_evt  <= 1'b0;
      done_evt   <= 1'b0;
    end else begin
      start_evt <= 1'b0;
      done_evt  <= 1'b0;
      if (!busy) begin
        if (run) begin
          busy      <= 1'b1;
          cs_n      <= 1'b0;
          ph        <= '0;
          start_evt <= 1'b1;
        end
      end else if (fall_evt) begin
        sclk <= 1'b0;
        ph   <= ph + PH_W'(1);
        if (ph == '0) begin
          frame_addr <= next_addr;
          frame_scan <= scan_mode;
          din        <= cmd_bit(next_addr, '0);
          if (scan_mode) ptr <= step_addr(ptr, N_CH);
        end else begin
          din <= cmd_bit(frame_addr, bit_idx);
        end
      end else if (rise_evt) begin
        sclk       <= 1'b1;
        frame_word <= {frame_word[FRAME_BITS-2:0], dout};
        if (ph == LAST_PH) begin
          done_evt <= 1'b1;
          ph       <= run ? '0 : TAIL_PH;
        end else begin
          ph <= ph + PH_W'(1);
        end
      end else if (tail_evt) begin
        cs_n <= 1'b1;
        busy <= 1'b0;
        din  <= 1'b0;
        ph   <= '0;
      end
    end
  end
endmodule

// File: rtl/adc_tag_pipe.sv
module adc_tag_pipe
  import adc_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start_evt,
  input  logic  done_evt,
  input  addr_t frame_addr,
  input  logic  frame_scan,
  input  word_t frame_word,
  output logic  res_valid,
  output res_t  res_data,
  output addr_t res_chan
);
  addr_t prev_addr;
  logic  prev_ok;
  logic  keep_evt;

  assign keep_evt = prev_ok && (frame_scan || (frame_addr == prev_addr));

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_chan  <= '0;
      prev_addr <= '0;
      prev_ok   <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (start_evt) begin
        prev_ok <= 1'b0;
      end else if (done_evt) begin
        res_valid <= keep_evt;
        res_data  <= word_result(frame_word);
        res_chan  <= prev_addr;
        prev_addr <= frame_addr;
        prev_ok   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int HALF_DIV = 40,
  parameter int N_CH     = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        run,
  input  logic        scan_mode,
  input  logic [2:0]  chan_sel,
  input  logic        adc_dout,
  output logic        adc_cs_n,
  output logic        adc_sclk,
  output logic        adc_din,
  output logic        res_valid,
  output logic [11:0] res_data,
  output logic [2:0]  res_chan
);
  logic  tick, busy, start_evt, done_evt, frame_scan;
  addr_t frame_addr;
  word_t frame_word;

  adc_sclk_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .hold(!busy),
    .tick(tick)
  );

  adc_frame_seq #(.N_CH(N_CH)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .run       (run),
    .scan_mode (scan_mode),
    .chan_sel  (chan_sel),
    .dout      (adc_dout),
    .cs_n      (adc_cs_n),
    .sclk      (adc_sclk),
    .din       (adc_din),
    .busy      (busy),
    .start_evt (start_evt),
    .done_evt  (done_evt),
    .frame_addr(frame_addr),
    .frame_scan(frame_scan),
    .frame_word(frame_word)
  );

  adc_tag_pipe u_tag (
    .clk       (clk),
    .rst       (rst),
    .start_evt (start_evt),
    .done_evt  (done_evt),
    .frame_addr(frame_addr),
    .frame_scan(frame_scan),
    .frame_word(frame_word),
    .res_valid (res_valid),
    .res_data  (res_data),
    .res_chan  (res_chan)
  );
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic adc_cs_n,
  input logic adc_sclk,
  input logic adc_din,
  input logic res_valid
);
  // R1
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (adc_cs_n && adc_sclk && !res_valid));

  // R2
  p_idle_clock_high_r2: assert property (@(posedge clk) disable iff (rst)
    adc_cs_n |-> adc_sclk);

  // R3
  p_fall_inside_frame_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_sclk) |-> (!adc_cs_n && $past(!adc_cs_n)));

  // R3
  p_select_rise_clock_high_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_cs_n) |-> (adc_sclk && $past(adc_sclk)));

  // R4
  p_cmd_moves_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(adc_din) |-> ($fell(adc_sclk) || $rose(adc_cs_n)));

  // R9
  p_valid_single_r9: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .adc_cs_n (adc_cs_n),
  .adc_sclk (adc_sclk),
  .adc_din  (adc_din),
  .res_valid(res_valid)
);

// File: tb/adc_seq_ctrl_test.sv
`timescale 1ns/1ps
module adc_seq_ctrl_test;
  localparam int HALF = 3;
  localparam int NCH  = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        scan_mode = 1'b0;
  logic [2:0]  chan_sel = 3'd0;
  logic        adc_dout = 1'b0;
  logic        adc_cs_n, adc_sclk, adc_din, res_valid;
  logic [11:0] res_data;
  logic [2:0]  res_chan;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  adc_seq_ctrl #(.HALF_DIV(HALF), .N_CH(NCH)) uut (
    .clk(clk), .rst(rst), .run(run), .scan_mode(scan_mode),
    .chan_sel(chan_sel), .adc_dout(adc_dout),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_din(adc_din),
    .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int next_ptr(input int p);
    return (p + 1) % NCH;
  endfunction

  // ---------------- converter model ----------------
  int          fc = 0;
  int          rc = 0;
  logic [11:0] cur_val;
  logic [3:0]  junk;
  logic [2:0]  sel_at_start;
  logic [2:0]  sent;
  logic [2:0]  prev_sent;
  bit          have_prev = 1'b0;
  int          scan_exp = 0;
  logic [14:0] expq[$];
  event        mid_frame;

  always @(negedge adc_cs_n) begin
    fc = 0;
    rc = 0;
  end

  always @(posedge adc_cs_n) begin
    if (!rst) chk(rc == 0, "R3 rising edges per frame", rc, 0);
    have_prev = 1'b0;
  end

  always @(negedge adc_sclk) begin
    if (adc_cs_n === 1'b0) begin
      if (fc == 0) begin
        cur_val      = 12'($urandom);
        junk         = 4'($urandom);
        sel_at_start = chan_sel;
      end
      adc_dout = (fc < 4) ? junk[fc] : cur_val[15 - fc];
      fc = (fc == 15) ? 0 : fc + 1;
    end
  end

  always @(posedge adc_sclk) begin
    if (adc_cs_n === 1'b0) begin
      if (rc >= 2 && rc <= 4) sent[4 - rc] = adc_din;
      else chk(adc_din == 1'b0, "R4 idle command bit", int'(adc_din), 0);
      rc++;
      if (rc == 8) -> mid_frame;
      if (rc == 16) begin
        rc = 0;
        if (scan_mode) begin
          chk(int'(sent) == scan_exp, "R8 scan address", int'(sent), scan_exp);
          scan_exp = next_ptr(scan_exp);
        end else begin
          chk(sent == sel_at_start, "R4 fixed address", int'(sent), int'(sel_at_start));
        end
        if (have_prev && (scan_mode || sent == prev_sent))
          expq.push_back({prev_sent, cur_val});
        prev_sent = sent;
        have_prev = 1'b1;
      end
    end
  end

  // ---------------- cycle monitor ----------------
  logic ps, pc, pv;
  int   gap;
  always @(negedge clk) begin
    if (rst) begin
      ps = 1'b1; pc = 1'b1; pv = 1'b0; gap = 0;
    end else begin
      if (adc_sclk != ps || adc_cs_n != pc) begin
        if (adc_sclk != ps)
          chk(!adc_cs_n && !pc, "R2 clock moves only while selected", int'(adc_cs_n), 0);
        if (!(pc && !adc_cs_n))
          chk(gap == HALF, "R2 R3 half-period spacing", gap, HALF);
        gap = 1;
      end else begin
        gap++;
      end
      if (res_valid) begin
        chk(!pv, "R9 single-cycle valid", int'(pv), 0);
        if (expq.size() == 0) begin
          chk(1'b0, "R7 unexpected result", int'({res_chan, res_data}), -1);
        end else begin
          logic [14:0] e;
          e = expq.pop_front();
          chk(res_data == e[11:0], "R5 result data", int'(res_data), int'(e[11:0]));
          chk(res_chan == e[14:12], "R6 result tag", int'(res_chan), int'(e[14:12]));
        end
      end
      ps = adc_sclk; pc = adc_cs_n; pv = res_valid;
    end
  end

  // ---------------- stimulus ----------------
  task automatic run_session(input bit sc, input int n, input bit vary);
    @(negedge clk);
    scan_mode = sc;
    run = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(mid_frame);
      @(negedge clk);
      if (i == n - 1) run = 1'b0;
      else if (vary && !sc && ($urandom % 2 == 0)) chan_sel = 3'($urandom % 8);
    end
    @(posedge adc_cs_n);
    repeat (5) @(negedge clk);
    chk(expq.size() == 0, "R9 all results delivered", expq.size(), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    chk(adc_cs_n == 1'b1, "R1 select high in reset", int'(adc_cs_n), 1);
    chk(adc_sclk == 1'b1, "R1 clock high in reset", int'(adc_sclk), 1);
    chk(res_valid == 1'b0, "R1 valid low in reset", int'(res_valid), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(adc_cs_n == 1'b1 && adc_sclk == 1'b1, "R1 idle after reset",
        int'({adc_cs_n, adc_sclk}), 3);

    // scan past the wrap point; first address must be 0 (R1, R8)
    run_session(1'b1, 10, 1'b0);
    // fixed input, stable: n-1 results (R6, R7)
    chan_sel = 3'd5;
    run_session(1'b0, 4, 1'b0);
    // single frame gives nothing (R7)
    chan_sel = 3'd2;
    run_session(1'b0, 1, 1'b0);
    // fixed input with random changes (R7 discard)
    run_session(1'b0, 8, 1'b1);
    // scan resumes from kept pointer (R8)
    run_session(1'b1, 5, 1'b0);
    // edge addresses (R4)
    chan_sel = 3'd7;
    run_session(1'b0, 3, 1'b0);
    chan_sel = 3'd0;
    run_session(1'b0, 2, 1'b0);
    // random sessions
    for (int s = 0; s < 6; s++) begin
      bit sc;
      int n;
      sc = 1'($urandom % 2);
      n  = 1 + int'($urandom % 5);
      chan_sel = 3'($urandom % 8);
      run_session(sc, n, 1'b1);
    end
    chk(scan_exp < NCH, "R8 pointer range", scan_exp, NCH - 1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule